// File: doc/BRIEF.md
# Two-Class Link Receive Deframer

This block sits after word alignment on the receive side of a serial link. It watches a stream of 16-bit words and finds packet boundaries. It sends the payload of each packet to one of two output streams: bulk data or slow control. Each class has its own start code. Both classes share one end code.

Every packet carries a CRC-16 word just before the end code. The block strips that word, checks it against a CRC it computes over the forwarded payload, and then closes the packet with an end-of-packet strobe on the stream that carried it. The strobe is marked bad if the check failed. An error strobe fires at the same time.

Payload words leave one word late, because a word can only be known to be payload once the next word shows it was not the CRC. There is no storage beyond the current packet.

Top module: `lnk_rx_demux`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dat_valid`, `sc_valid`, `dat_eop`, `sc_eop`, `dat_bad`, `sc_bad` and `err_pulse` are all 0.
- R2: While no packet is open, every accepted word other than 0x95FB and 0x951C is discarded. This includes the end code 0x95FD. Discarded words cause no output activity.
- R3: The start code 0x95FB opens a data-class packet. Its payload words appear on `dat_word` in arrival order, each with `dat_valid` high for one cycle. A payload word is presented in the cycle after the clock edge that accepts the next word of the packet.
- R4: The start code 0x951C opens a slow-control packet. Its payload is presented on `sc_word` and `sc_valid` with the same ordering and timing as R3. Nothing appears on the data stream.
- R5: The last word before the end code 0x95FD is the received CRC. It is never forwarded on either stream.
- R6: Suppose the edge at cycle m accepts the end code. Then the packet class's eop strobe (`dat_eop` or `sc_eop`) is high for exactly the one cycle that follows edge m+1.
- R7: The bad flag (`dat_bad` or `sc_bad`) and `err_pulse` are both high in the eop cycle exactly when the CRC check fails. For a good packet, both are low.
- R8: The CRC has these properties:
  - polynomial 0x1021, initial value 0xFFFF;
  - each payload word is fed most-significant bit first;
  - there is no final inversion;
  - the CRC is computed over the forwarded payload words only.
  For example, a packet with no payload words expects the CRC word 0xFFFF.
- R9: A start code that arrives while a packet is open aborts that packet. In the next cycle the aborted class gets an eop strobe with bad set, together with `err_pulse`. The word held back as a possible CRC is dropped. The new packet then opens according to R3 or R4.
- R10: An end code that follows the start code directly, with no CRC word, ends the packet as bad, with `err_pulse` asserted.
- R11: Cycles with `in_valid` low are ignored. They do not advance the packet and they produce no `dat_valid` or `sc_valid` in the next cycle.
- R12: On each stream, valid and eop are never high in the same cycle. The two streams are never valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_word` in this cycle |
| in_word | input | 16 | Received link word |
| dat_valid | output | 1 | `dat_word` carries a data payload word |
| dat_word | output | 16 | Data-class payload word |
| dat_eop | output | 1 | Data-class packet ended |
| dat_bad | output | 1 | Data packet failed its check or was aborted (only with `dat_eop`) |
| sc_valid | output | 1 | `sc_word` carries a slow-control payload word |
| sc_word | output | 16 | Slow-control payload word |
| sc_eop | output | 1 | Slow-control packet ended |
| sc_bad | output | 1 | Slow-control packet failed or was aborted (only with `sc_eop`) |
| err_pulse | output | 1 | One-cycle error strobe |

## Verification
A wrong class register would show up within one word. Payload would appear on the wrong stream, or the eop would close the other stream. A held-back word that was lost or duplicated would shift the forwarded sequence. That is visible at the next payload word or at the end code, because the stripped CRC would then either leak out or cost a real payload word. A corrupted running CRC stays hidden until the end code, and then shows as a bad flag and an error strobe two edges after that code. The directed packets therefore compare whole word sequences and the end-event order, and check the eop cycle exactly once.

// File: rtl/lnk_rx_pkg.sv
package lnk_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_PKT   = 2'd1,
        RX_CHECK = 2'd2
    } rx_state_e;

    localparam int unsigned N_CLASS = 2;
    localparam int unsigned CLS_DAT = 0;
    localparam int unsigned CLS_SC  = 1;
endpackage

// File: rtl/lnk_rx_classify.sv
module lnk_rx_classify #(
    parameter int unsigned  WORD_W   = 16,
    parameter logic [15:0]  SOP_DAT  = 16'h95FB,
    parameter logic [15:0]  SOP_SC   = 16'h951C,
    parameter logic [15:0]  EOP_CODE = 16'h95FD
) (
    input  logic [WORD_W-1:0] word,
    output logic              is_sop,
    output logic              sop_cls,
    output logic              is_eop
);
    always_comb begin
        is_sop  = (word == WORD_W'(SOP_DAT)) || (word == WORD_W'(SOP_SC));
        sop_cls = (word == WORD_W'(SOP_SC));
        is_eop  = (word == WORD_W'(EOP_CODE));
    end
endmodule

// File: rtl/lnk_rx_crc_step.sv
module lnk_rx_crc_step #(
    parameter int unsigned  WORD_W = 16,
    parameter int unsigned  CRC_W  = 16,
    parameter logic [15:0]  POLY   = 16'h1021
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [WORD_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] acc;
    logic             fb;

    // Serial CRC unrolled over one word, MSB of the word first.
    always_comb begin
        acc = crc_in;
        fb  = 1'b0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ data[i];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ CRC_W'(POLY);
            end
        end
        crc_out = acc;
    end
endmodule

// File: rtl/lnk_rx_demux.sv
module lnk_rx_demux #(
    parameter int unsigned  WORD_W   = 16,
    parameter logic [15:0]  SOP_DAT  = 16'h95FB,
    parameter logic [15:0]  SOP_SC   = 16'h951C,
    parameter logic [15:0]  EOP_CODE = 16'h95FD,
    parameter logic [15:0]  CRC_POLY = 16'h1021,
    parameter logic [15:0]  CRC_INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              dat_valid,
    output logic [WORD_W-1:0] dat_word,
    output logic              dat_eop,
    output logic              dat_bad,
    output logic              sc_valid,
    output logic [WORD_W-1:0] sc_word,
    output logic              sc_eop,
    output logic              sc_bad,
    output logic              err_pulse
);
    import lnk_rx_pkg::*;

    localparam int unsigned CRC_W = WORD_W;

    typedef struct packed {
        rx_state_e            state;
        logic                 cls;
        logic [CRC_W-1:0]     crc;
        logic [WORD_W-1:0]    pend;
        logic                 pend_v;
        logic [N_CLASS-1:0]   out_v;
        logic [WORD_W-1:0]    out_w;
        logic [N_CLASS-1:0]   out_eop;
        logic                 out_bad;
        logic                 err;
    } rx_st_t;

    rx_st_t st_d, st_q;

    logic             w_sop, w_cls, w_eop;
    logic [CRC_W-1:0] crc_adv;

    lnk_rx_classify #(
        .WORD_W  (WORD_W),
        .SOP_DAT (SOP_DAT),
        .SOP_SC  (SOP_SC),
        .EOP_CODE(EOP_CODE)
    ) u_classify (
        .word   (in_word),
        .is_sop (w_sop),
        .sop_cls(w_cls),
        .is_eop (w_eop)
    );

    // Running CRC advanced by the held word as it is released.
    lnk_rx_crc_step #(
        .WORD_W(WORD_W),
        .CRC_W (CRC_W),
        .POLY  (CRC_POLY)
    ) u_crc (
        .crc_in (st_q.crc),
        .data   (st_q.pend),
        .crc_out(crc_adv)
    );

    always_comb begin
        st_d         = st_q;
        st_d.out_v   = '0;
        st_d.out_eop = '0;
        st_d.out_bad = 1'b0;
        st_d.err     = 1'b0;

        unique case (st_q.state)
            RX_IDLE: begin
                if (in_valid && w_sop) begin
                    st_d.state  = RX_PKT;
                    st_d.cls    = w_cls;
                    st_d.crc    = CRC_W'(CRC_INIT);
                    st_d.pend_v = 1'b0;
                end
            end
            RX_CHECK: begin
                st_d.out_eop[st_q.cls] = 1'b1;
                st_d.out_bad = !st_q.pend_v || (st_q.crc != st_q.pend);
                st_d.err     = st_d.out_bad;
                st_d.state   = RX_IDLE;
                st_d.pend_v  = 1'b0;
                if (in_valid && w_sop) begin
                    st_d.state = RX_PKT;
                    st_d.cls   = w_cls;
                    st_d.crc   = CRC_W'(CRC_INIT);
                end
            end
            RX_PKT: begin
                if (in_valid) begin
                    if (w_sop) begin
                        // Abort the open packet and start the new one.
                        st_d.out_eop[st_q.cls] = 1'b1;
                        st_d.out_bad = 1'b1;
                        st_d.err     = 1'b1;
                        st_d.cls     = w_cls;
                        st_d.crc     = CRC_W'(CRC_INIT);
                        st_d.pend_v  = 1'b0;
                    end else if (w_eop) begin
                        st_d.state = RX_CHECK;
                    end else begin
                        if (st_q.pend_v) begin
                            st_d.out_v[st_q.cls] = 1'b1;
                            st_d.out_w = st_q.pend;
                            st_d.crc   = crc_adv;
                        end
                        st_d.pend   = in_word;
                        st_d.pend_v = 1'b1;
                    end
                end
            end
            default: begin
                st_d.state = RX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dat_valid = st_q.out_v[CLS_DAT];
    assign sc_valid  = st_q.out_v[CLS_SC];
    assign dat_word  = st_q.out_w;
    assign sc_word   = st_q.out_w;
    assign dat_eop   = st_q.out_eop[CLS_DAT];
    assign sc_eop    = st_q.out_eop[CLS_SC];
    assign dat_bad   = st_q.out_eop[CLS_DAT] & st_q.out_bad;
    assign sc_bad    = st_q.out_eop[CLS_SC] & st_q.out_bad;
    assign err_pulse = st_q.err;
endmodule

// File: rtl/lnk_rx_demux_chk.sv
module lnk_rx_demux_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic dat_valid,
    input logic dat_eop,
    input logic dat_bad,
    input logic sc_valid,
    input logic sc_eop,
    input logic sc_bad,
    input logic err_pulse
);
    AST_ONE_STREAM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_valid && sc_valid)); // R12

    AST_DAT_VALID_NOT_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_valid && dat_eop)); // R12

    AST_SC_VALID_NOT_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        !(sc_valid && sc_eop)); // R12

    AST_ERR_MARKS_BAD_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> ((dat_eop && dat_bad) || (sc_eop && sc_bad))); // R7

    AST_BAD_NEEDS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_bad || sc_bad) |-> err_pulse); // R7

    AST_IDLE_INPUT_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!dat_valid && !sc_valid)); // R11
endmodule

bind lnk_rx_demux lnk_rx_demux_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .dat_valid(dat_valid),
    .dat_eop  (dat_eop),
    .dat_bad  (dat_bad),
    .sc_valid (sc_valid),
    .sc_eop   (sc_eop),
    .sc_bad   (sc_bad),
    .err_pulse(err_pulse)
);

// File: tb/lnk_rx_demux_bench.sv
module lnk_rx_demux_bench;
    localparam logic [15:0] K_SOP_D = 16'h95FB;
    localparam logic [15:0] K_SOP_S = 16'h951C;
    localparam logic [15:0] K_EOP   = 16'h95FD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        dat_valid, dat_eop, dat_bad, sc_valid, sc_eop, sc_bad, err_pulse;
    logic [15:0] dat_word, sc_word;

    int n_checks = 0;
    int n_errors = 0;
    int r12_viol = 0;
    bit gaps = 1'b0;
    bit mon_on = 1'b0;

    logic [15:0] got_d[$];
    logic [15:0] got_s[$];
    int          got_e[$];
    logic [15:0] exp_d[$];
    logic [15:0] exp_s[$];
    int          exp_e[$];
    logic [15:0] pay[$];

    always #5 clk = ~clk;

    lnk_rx_demux u_lnk_rx_demux (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .dat_valid(dat_valid), .dat_word(dat_word), .dat_eop(dat_eop), .dat_bad(dat_bad),
        .sc_valid(sc_valid), .sc_word(sc_word), .sc_eop(sc_eop), .sc_bad(sc_bad),
        .err_pulse(err_pulse)
    );

    // Event code: class*4 + bad*2 + err; 99 = error strobe without eop.
    always @(negedge clk) begin
        if (mon_on) begin
            if (dat_valid) got_d.push_back(dat_word);
            if (sc_valid)  got_s.push_back(sc_word);
            if (dat_eop)   got_e.push_back(int'(dat_bad) * 2 + int'(err_pulse));
            if (sc_eop)    got_e.push_back(4 + int'(sc_bad) * 2 + int'(err_pulse));
            if (err_pulse && !dat_eop && !sc_eop) got_e.push_back(99);
            if ((dat_valid && sc_valid) || (dat_valid && dat_eop) || (sc_valid && sc_eop))
                r12_viol++;
        end
    end

    function automatic logic [15:0] crc_upd(logic [15:0] c, logic [15:0] d);
        logic fb;
        for (int i = 15; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        got_d.delete(); got_s.delete(); got_e.delete();
        exp_d.delete(); exp_s.delete(); exp_e.delete();
        pay.delete();
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        if (gaps) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_word  = 16'hDEAD;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_word  = 16'h0BAD;
        end
    endtask

    // Sends start code, pay[], CRC (optionally corrupted) and end code.
    task automatic send_pkt(input logic [15:0] sop, input bit corrupt);
        logic [15:0] c = 16'hFFFF;
        send(sop);
        foreach (pay[i]) begin
            send(pay[i]);
            c = crc_upd(c, pay[i]);
        end
        send(corrupt ? (c ^ 16'h0001) : c);
        send(K_EOP);
    endtask

    task automatic compare(input string tag);
        chk(got_d.size() == exp_d.size(), {tag, " data word count"}, got_d.size(), exp_d.size());
        if (got_d.size() == exp_d.size())
            foreach (exp_d[i]) chk(got_d[i] == exp_d[i], {tag, " data word"}, got_d[i], exp_d[i]);
        chk(got_s.size() == exp_s.size(), {tag, " sc word count"}, got_s.size(), exp_s.size());
        if (got_s.size() == exp_s.size())
            foreach (exp_s[i]) chk(got_s[i] == exp_s[i], {tag, " sc word"}, got_s[i], exp_s[i]);
        chk(got_e.size() == exp_e.size(), {tag, " event count"}, got_e.size(), exp_e.size());
        if (got_e.size() == exp_e.size())
            foreach (exp_e[i]) chk(got_e[i] == exp_e[i], {tag, " event"}, got_e[i], exp_e[i]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        chk({dat_valid, sc_valid, dat_eop, sc_eop, dat_bad, sc_bad, err_pulse} == '0,
            "R1 outputs in reset", {dat_valid, sc_valid, dat_eop, sc_eop, err_pulse}, 0);
        rst_n = 1'b1;
        idle(1);
        chk({dat_valid, sc_valid, dat_eop, sc_eop, dat_bad, sc_bad, err_pulse} == '0,
            "R1 outputs after reset", {dat_valid, sc_valid, dat_eop, sc_eop, err_pulse}, 0);
        mon_on = 1'b1;
    endtask

    task automatic t_idle_junk();
        clear_all();
        send(16'h1234); send(K_EOP); send(16'h0000); send(16'h95FC);
        idle(4);
        compare("R2 idle discard");
    endtask

    // Also checks the R6 eop cycle exactly.
    task automatic t_data_good();
        clear_all();
        pay.push_back(16'hA001); pay.push_back(16'hB002); pay.push_back(16'hC003);
        exp_d = pay;
        exp_e.push_back(0);
        send_pkt(K_SOP_D, 1'b0);
        idle(1);
        chk(dat_eop == 1'b0, "R6 eop not before check cycle", dat_eop, 0);
        idle(1);
        chk(dat_eop == 1'b1, "R6 eop in cycle after check", dat_eop, 1);
        chk(err_pulse == 1'b0, "R7 no error on good crc", err_pulse, 0);
        idle(3);
        compare("R3 R5 R8 data packet");
    endtask

    task automatic t_sc_gaps();
        clear_all();
        gaps = 1'b1;
        pay.push_back(16'h0001); pay.push_back(16'hFFFF);
        pay.push_back(16'h95FE); pay.push_back(16'h7A5A);
        exp_s = pay;
        exp_e.push_back(4);
        send_pkt(K_SOP_S, 1'b0);
        gaps = 1'b0;
        idle(4);
        compare("R4 R11 sc packet with gaps");
    endtask

    task automatic t_bad_crc();
        clear_all();
        pay.push_back(16'h1111); pay.push_back(16'h2222);
        exp_d = pay;
        exp_e.push_back(3);
        send_pkt(K_SOP_D, 1'b1);
        idle(4);
        compare("R7 crc mismatch");
    endtask

    task automatic t_abort();
        logic [15:0] c;
        clear_all();
        send(K_SOP_D); send(16'h5A01); send(16'h5A02);
        exp_d.push_back(16'h5A01);
        exp_e.push_back(3);
        c = crc_upd(16'hFFFF, 16'h6B01);
        send(K_SOP_S); send(16'h6B01); send(c); send(K_EOP);
        exp_s.push_back(16'h6B01);
        exp_e.push_back(4);
        idle(4);
        compare("R9 abort by new start");
    endtask

    task automatic t_empty();
        clear_all();
        send(K_SOP_S); send(K_EOP);
        exp_e.push_back(7);
        idle(3);
        send(K_SOP_D); send(16'hFFFF); send(K_EOP);
        exp_e.push_back(0);
        idle(4);
        compare("R10 R8 empty packets");
    endtask

    task automatic t_back_to_back();
        clear_all();
        pay.push_back(16'h0D0D);
        send_pkt(K_SOP_D, 1'b0);
        exp_d.push_back(16'h0D0D);
        exp_e.push_back(0);
        pay.delete();
        pay.push_back(16'h0E0E); pay.push_back(16'h0F0F);
        send_pkt(K_SOP_S, 1'b0);
        exp_s = pay;
        exp_e.push_back(4);
        idle(4);
        compare("R3 R4 back to back packets");
        chk(r12_viol == 0, "R12 valid/eop exclusivity", r12_viol, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_idle_junk();
        t_data_good();
        t_sc_gaps();
        t_bad_crc();
        t_abort();
        t_empty();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule